// File: doc/BRIEF.md
# Burst Read Bus Responder

This block is the device side of a burst read over a shared, tri-stated 68-bit bidirectional bus. The host presents a read command, together with an address word, while it holds a command-valid strobe. The responder decodes the command and decides whether it is the target. It then stays off the bus for two turnaround cycles while the host releases it. After that it returns one word every two cycles: a preparation cycle in which it takes the data, acknowledge and end-of-transfer lines, then a data cycle in which it drives the word and raises acknowledge. On the final word, end-of-transfer is also high.

The low 15 address bits do not come from the host. An internal burst address counter supplies them and steps once per returned word. A burst-length input sets the number of words. Each tri-stated line has its own output enable, so that bus ownership can be observed directly. The storage is outside the block, behind a read port with one cycle of latency.

A device that is not selected still steps through the same cycle sequence, so it ignores the bus until the burst ends. All of its enables stay low for the whole time.

Top module: `burst_read_responder`

## Requirements
- R1: A burst read is accepted only when the block is idle and `cmd_valid` is 1 and `cmd_op` is 3'b101 (bit 2 = burst, bits [1:0] = 2'b01 = read). Any other value of `cmd_op` produces no bus activity and leaves the address counter unchanged.
- R2: The block is selected when `bus_in[25:21]` equals `dev_id`. The value 5'b11111 selects the block only when `last_dev` is 1.
- R3: `bus_in[20:19]` picks the array. 2'b00 gives `mem_sel`=0 (data array), 2'b01 gives `mem_sel`=1 (mask array), and 2'b1x leaves the block unselected. `bus_in[14:0]` has no effect on the words returned.
- R4: In the two cycles after the command cycle, `bus_oe`, `ack_oe` and `eot_oe` are all 0.
- R5: In the third cycle after the command cycle (the first preparation cycle), a selected block has `bus_oe`, `ack_oe` and `eot_oe` at 1, with `ack_out` and `eot_out` at 0.
- R6: In each data cycle, `bus_out` carries the word that the memory returns for (`mem_sel`, `mem_addr`), and `ack_out` is 1. The word is read through `mem_rd` in the preceding preparation cycle.
- R7: A burst returns `burst_len` words, or one word when `burst_len` is 0. `eot_out` is 1 only in the data cycle of the final word.
- R8: In the cycle after the final data cycle, `bus_oe` is 0, `ack_oe` and `eot_oe` are 1, and `ack_out` and `eot_out` are 0. In the cycle after that, all enables are 0 and a new command is accepted.
- R9: The first word of a burst is read at the counter value. The counter advances by one per word returned, wraps modulo 2^15, and is preset from `addr_ld_val` when `addr_ld` is 1.
- R10: An unselected block keeps all enables at 0 for the whole burst and does not advance its counter.
- R11: After reset, all enables are 0 and `mem_addr` is 0.
- R12: A read command presented while a burst is in progress is ignored. It neither extends nor restarts the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: bit 2 burst, bits [1:0] opcode |
| bus_in | input | 68 | Bus value as seen by the device |
| dev_id | input | 5 | This device's identifier |
| last_dev | input | 1 | This device is the last in the chain |
| burst_len | input | 8 | Words per burst (0 means 1) |
| addr_ld | input | 1 | Preset the burst address counter |
| addr_ld_val | input | 15 | Preset value |
| mem_rd | output | 1 | Array read strobe |
| mem_sel | output | 1 | Array select: 0 data, 1 mask |
| mem_addr | output | 15 | Array read address |
| mem_rdata | input | 68 | Array read word, one cycle after `mem_rd` |
| bus_out | output | 68 | Value driven onto the bus |
| bus_oe | output | 1 | Bus output enable |
| ack_out | output | 1 | Acknowledge value |
| ack_oe | output | 1 | Acknowledge output enable |
| eot_out | output | 1 | End-of-transfer value |
| eot_oe | output | 1 | End-of-transfer output enable |

## Verification
The assertions check the cycle-level rules on every cycle:
- the quiet turnaround after an accepted command;
- the data, acknowledge and end-of-transfer enables rising together;
- acknowledge appearing only with the data enable, and end-of-transfer only with acknowledge;
- the low-then-release sequence at the end of a burst;
- the single-step advance of the address counter.

Other properties depend on which device is addressed and on the memory contents. These are word counts, the zero-length case, the broadcast ID with and without the last-device flag, the reserved array codes, address wrap, and commands arriving mid-burst. Only the bench scenarios show them, by comparing every returned word with a scoreboard.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TA1,
    ST_TA2,
    ST_PREP,
    ST_DATA,
    ST_TERM
  } rsp_state_t;

  localparam logic [1:0] OP_READ  = 2'b01;
  localparam int         ID_W     = 5;
  localparam logic [ID_W-1:0] ID_ALL = '1;
endpackage

// File: rtl/rsp_select.sv
module rsp_select
  import rsp_pkg::*;
(
  input  logic            cmd_valid,
  input  logic [2:0]      cmd_op,
  input  logic [ID_W-1:0] id_field,
  input  logic [1:0]      arr_field,
  input  logic [ID_W-1:0] dev_id,
  input  logic            last_dev,
  output logic            cmd_hit,
  output logic            sel_hit,
  output logic            arr_sel
);
  logic id_match;

  assign cmd_hit  = cmd_valid && cmd_op[2] && (cmd_op[1:0] == OP_READ);
  assign id_match = (id_field == ID_ALL) ? last_dev : (id_field == dev_id);
  assign sel_hit  = id_match && !arr_field[1];
  assign arr_sel  = arr_field[0];
endmodule

// File: rtl/rsp_seq.sv
module rsp_seq
  import rsp_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_hit,
  input  logic             sel_hit,
  input  logic [LEN_W-1:0] burst_len,
  output rsp_state_t       state,
  output logic             sel_q,
  output logic             last_word
);
  logic [LEN_W-1:0] rem_q;

  function automatic logic [LEN_W-1:0] eff_len(input logic [LEN_W-1:0] l);
    return (l == '0) ? LEN_W'(1) : l;
  endfunction

  assign last_word = (state == ST_DATA) && (rem_q == LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sel_q <= 1'b0;
      rem_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (cmd_hit) begin
          state <= ST_TA1;
          sel_q <= sel_hit;
          rem_q <= eff_len(burst_len);
        end
        ST_TA1:  state <= ST_TA2;
        ST_TA2:  state <= ST_PREP;
        ST_PREP: state <= ST_DATA;
        ST_DATA: begin
          rem_q <= rem_q - LEN_W'(1);
          state <= (rem_q == LEN_W'(1)) ? ST_TERM : ST_PREP;
        end
        ST_TERM: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rsp_addr_ctr.sv
module rsp_addr_ctr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic              inc,
  output logic [ADDR_W-1:0] addr
);
  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr <= '0;
    else if (ld)  addr <= ld_val;
    else if (inc) addr <= step(addr);
  end
endmodule

// File: rtl/burst_read_responder.sv
module burst_read_responder
  import rsp_pkg::*;
#(
  parameter int BUS_W  = 68,
  parameter int ADDR_W = 15,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BUS_W-1:0]  bus_in,
  input  logic [ID_W-1:0]   dev_id,
  input  logic              last_dev,
  input  logic [LEN_W-1:0]  burst_len,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_ld_val,
  output logic              mem_rd,
  output logic              mem_sel,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [BUS_W-1:0]  mem_rdata,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe,
  output logic              ack_out,
  output logic              ack_oe,
  output logic              eot_out,
  output logic              eot_oe
);
  localparam int ID_LO  = 21;
  localparam int ARR_LO = 19;

  logic       cmd_hit, sel_hit, arr_sel, arr_q;
  logic       sel_q, last_word, idle, word_done;
  rsp_state_t state;
  logic       unused_bus;

  assign unused_bus = ^{bus_in[BUS_W-1:ID_LO+ID_W], bus_in[ARR_LO-1:0]};

  rsp_select u_sel (
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .id_field  (bus_in[ID_LO +: ID_W]),
    .arr_field (bus_in[ARR_LO +: 2]),
    .dev_id    (dev_id),
    .last_dev  (last_dev),
    .cmd_hit   (cmd_hit),
    .sel_hit   (sel_hit),
    .arr_sel   (arr_sel)
  );

  rsp_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_hit   (cmd_hit),
    .sel_hit   (sel_hit),
    .burst_len (burst_len),
    .state     (state),
    .sel_q     (sel_q),
    .last_word (last_word)
  );

  assign idle      = (state == ST_IDLE);
  assign word_done = (state == ST_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                arr_q <= 1'b0;
    else if (idle && cmd_hit)  arr_q <= arr_sel;
  end

  rsp_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (addr_ld),
    .ld_val (addr_ld_val),
    .inc    (word_done && sel_q),
    .addr   (mem_addr)
  );

  assign mem_rd  = sel_q && (state == ST_PREP);
  assign mem_sel = arr_q;
  assign bus_oe  = sel_q && (state == ST_PREP || state == ST_DATA);
  assign ack_oe  = sel_q && (state == ST_PREP || state == ST_DATA || state == ST_TERM);
  assign eot_oe  = ack_oe;
  assign ack_out = sel_q && word_done;
  assign eot_out = sel_q && last_word;
  assign bus_out = (sel_q && word_done) ? mem_rdata : '0;
endmodule

// File: rtl/rsp_checker.sv
module rsp_checker #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_hit,
  input logic              idle,
  input logic              sel_q,
  input logic              word_done,
  input logic              addr_ld,
  input logic              bus_oe,
  input logic              ack_oe,
  input logic              eot_oe,
  input logic              ack_out,
  input logic              eot_out,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr
);
  assert_turnaround_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && idle) |=> (!bus_oe && !ack_oe && !eot_oe));

  assert_turnaround_second_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && idle) |=> ##1 (!bus_oe && !ack_oe && !eot_oe));

  assert_enables_together_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (ack_oe && eot_oe));

  assert_ack_with_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> (bus_oe && ack_oe));

  assert_read_then_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ack_out);

  assert_eot_needs_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eot_out |-> ack_out);

  assert_release_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |-> (ack_oe && eot_oe && !ack_out && !eot_out));

  assert_ack_float_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_oe) |=> (!ack_oe && !eot_oe));

  assert_addr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && sel_q && !addr_ld) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  assert_unsel_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> (!bus_oe && !ack_oe && !eot_oe && !mem_rd));
endmodule

bind burst_read_responder rsp_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_hit   (cmd_hit),
  .idle      (idle),
  .sel_q     (sel_q),
  .word_done (word_done),
  .addr_ld   (addr_ld),
  .bus_oe    (bus_oe),
  .ack_oe    (ack_oe),
  .eot_oe    (eot_oe),
  .ack_out   (ack_out),
  .eot_out   (eot_out),
  .mem_rd    (mem_rd),
  .mem_addr  (mem_addr)
);

// File: tb/sim_burst_read_responder.sv
module sim_burst_read_responder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [67:0] bus_in = '0;
  logic [4:0]  dev_id = 5'd9;
  logic        last_dev = 1'b0;
  logic [7:0]  burst_len = '0;
  logic        addr_ld = 1'b0;
  logic [14:0] addr_ld_val = '0;
  logic        mem_rd, mem_sel;
  logic [14:0] mem_addr;
  logic [67:0] mem_rdata = '0;
  logic [67:0] bus_out;
  logic        bus_oe, ack_out, ack_oe, eot_out, eot_oe;

  int checks = 0;
  int errors = 0;
  logic [14:0] tb_addr = '0;
  logic [68:0] expq[$];
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_read_responder u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .bus_in(bus_in), .dev_id(dev_id), .last_dev(last_dev), .burst_len(burst_len),
    .addr_ld(addr_ld), .addr_ld_val(addr_ld_val), .mem_rd(mem_rd), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .bus_out(bus_out), .bus_oe(bus_oe),
    .ack_out(ack_out), .ack_oe(ack_oe), .eot_out(eot_out), .eot_oe(eot_oe)
  );

  function automatic logic [67:0] pat(input logic s, input logic [14:0] a);
    return {s, a, ~a, a ^ 15'h2A5A, 22'(a) * 22'd3};
  endfunction

  always_ff @(posedge clk) if (mem_rd) mem_rdata <= pat(mem_sel, mem_addr);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [68:0] act, input logic [68:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic quiet(input string req, input string what);
    chk(!bus_oe && !ack_oe && !eot_oe, req, what, 69'({bus_oe, ack_oe, eot_oe}), 69'd0);
  endtask

  // monitor: pops the scoreboard on every data cycle
  always @(negedge clk) begin
    if (rst_n && bus_oe && ack_out) begin
      if (expq.size() == 0) begin
        chk(0, "R7", "unexpected word", {eot_out, bus_out}, 69'd0);
      end else begin
        logic [68:0] e;
        e = expq.pop_front();
        chk({eot_out, bus_out} == e, "R6", "word/eot", {eot_out, bus_out}, e);
      end
    end
  end

  task automatic preset(input logic [14:0] a);
    addr_ld = 1'b1; addr_ld_val = a;
    @(posedge clk); @(negedge clk);
    addr_ld = 1'b0;
    tb_addr = a;
  endtask

  // called at a negedge; drives one command cycle and follows the burst
  task automatic issue(input logic [4:0] id, input logic [1:0] arr, input logic [2:0] op,
                       input int blen, input bit sel, input bit inject);
    int n;
    n = (blen == 0) ? 1 : blen;
    if (sel)
      for (int k = 0; k < n; k++)
        expq.push_back({(k == n - 1), pat(arr[0], tb_addr + 15'(k))});
    cmd_valid = 1'b1; cmd_op = op; burst_len = 8'(blen);
    bus_in = {42'h2AB_CDEF_0123, id, arr, 4'hF, 15'h5B3C};
    @(posedge clk); @(negedge clk);
    cmd_valid = 1'b0; bus_in = '0;
    if (op != 3'b101) begin
      for (int c = 0; c < 4; c++) begin
        quiet("R1", "non-read command");
        @(negedge clk);
      end
      return;
    end
    quiet("R4", "turnaround cycle 2");
    @(negedge clk);
    quiet("R4", "turnaround cycle 3");
    if (inject) begin
      cmd_valid = 1'b1; cmd_op = 3'b101; bus_in = {42'd0, dev_id, 2'b00, 19'd0};
    end
    @(negedge clk);
    cmd_valid = 1'b0; bus_in = '0;
    if (sel)
      chk(bus_oe && ack_oe && eot_oe && !ack_out && !eot_out, "R5", "first prep cycle",
          69'({bus_oe, ack_oe, eot_oe, ack_out, eot_out}), 69'b11100);
    else
      quiet("R10", "unselected prep");
    for (int c = 0; c < 2 * n - 1; c++) begin
      @(negedge clk);
      if (!sel) quiet("R10", "unselected burst");
    end
    @(negedge clk);
    if (sel)
      chk(!bus_oe && ack_oe && eot_oe && !ack_out && !eot_out, "R8", "termination cycle",
          69'({bus_oe, ack_oe, eot_oe, ack_out, eot_out}), 69'b01100);
    else
      quiet("R10", "unselected termination");
    @(negedge clk);
    quiet("R8", "released after burst");
    chk(expq.size() == 0, "R7", "words outstanding", 69'(expq.size()), 69'd0);
    expq.delete();
    if (sel) tb_addr = tb_addr + 15'(n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    quiet("R11", "during reset");
    rst_n = 1'b1;
    @(negedge clk);
    quiet("R11", "after reset");
    chk(mem_addr == 15'd0, "R11", "counter reset", 69'(mem_addr), 69'd0);

    issue(5'd9, 2'b00, 3'b101, 1, 1, 0);   // R2 id match, data array
    issue(5'd9, 2'b01, 3'b101, 4, 1, 0);   // R3 mask array, R7 four words
    issue(5'd9, 2'b00, 3'b101, 0, 1, 0);   // R7 zero length -> one word
    issue(5'd31, 2'b00, 3'b101, 2, 0, 0);  // R2 broadcast, not last
    last_dev = 1'b1;
    issue(5'd31, 2'b01, 3'b101, 2, 1, 0);  // R2 broadcast, last
    issue(5'd4, 2'b00, 3'b101, 3, 0, 0);   // R10 other id
    issue(5'd9, 2'b10, 3'b101, 2, 0, 0);   // R3 reserved array code
    issue(5'd9, 2'b00, 3'b001, 2, 0, 0);   // R1 single access, not burst
    issue(5'd9, 2'b00, 3'b100, 2, 0, 0);   // R1 wrong opcode
    issue(5'd9, 2'b00, 3'b101, 1, 1, 0);   // R9 counter untouched by above
    preset(15'h7FFE);
    issue(5'd9, 2'b01, 3'b101, 3, 1, 0);   // R9 wrap 7FFE,7FFF,0000
    chk(mem_addr == 15'd1, "R9", "after wrap", 69'(mem_addr), 69'd1);
    issue(5'd9, 2'b00, 3'b101, 2, 1, 1);   // R12 mid-burst command ignored
    repeat (8) begin
      @(negedge clk);
      quiet("R12", "no restarted burst");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule